// File: doc/BRIEF.md
# Fixed-Point Exponential Smoothing Filter

This block is a first-order recursive low-pass filter (an exponential moving average) for slowly sampled signals, such as the demodulated output of a lock-in detector. An internal counter with a programmable period produces sample strikes. On each strike the block reads a signed fixed-point sample and moves its wide feedback state toward that sample by a run-time fraction of the remaining gap. One cycle later it presents a rounded, saturated output together with a one-clock valid pulse.

The coefficient can be used in two ways. It can be a 16-bit unsigned fraction applied through one multiply. It can also be a power of two 2^-m, in which case the multiply becomes an arithmetic right shift. The feedback state has 40 bits, which is far wider than the 18-bit sample. This keeps round-off from building up in the loop when the coefficient is small and the input is tiny. Converting a time constant into a coefficient is left to the user: for example 1 - exp(-1/(fs*tau)) for a time constant tau at sample rate fs.

Top module: `ema_smoother`

## Requirements
- R1: While `rst_n` is low, and for the first two rising clock edges after it goes high, the state and the sample counter stay cleared. During that time `sample_out` reads 0 and `out_valid` reads 0.
- R2: With `period` = P ≥ 1, a strike occurs every P clocks. P = 0 behaves as P = 1. `out_valid` is high for exactly the one clock after each strike cycle, unless `clear` was high in that strike cycle.
- R3: In multiply mode (`shift_mode` = 0), a strike sets the state to y + floor(a·(x − y)). Here x is `sample_in` (two's complement, 17 fraction bits), a is `alpha`/65536 (unsigned, 16 fraction bits), and y is the state (two's complement, 40 bits, 39 fraction bits). The difference x − y is formed without overflow.
- R4: In shift mode (`shift_mode` = 1), a strike sets the state to y + floor((x − y)/2^m), where m = `shift_amt`. With m = 0 the output equals the sampled input after the update.
- R5: `sample_out` is the state rounded half-up to 17 fraction bits: floor((state·2^39 + 2^21)/2^22)/2^17, saturated to 0x1FFFF and 0x20000. It changes only in the clock after a strike or after a clear.
- R6: `clear` high in a cycle sets the state to zero at the next edge. It suppresses any update and valid pulse from a strike in the same cycle, and it leaves the sample counter running.
- R7: `alpha`, `shift_mode`, `shift_amt` and `sample_in` are used only in strike cycles. Changing them between strikes has no effect on the output.
- R8: From a zero state with constant input 0x1FFFF and period 1, the number of strikes for the output to go from at least 10% of full scale to at least 90% of full scale is 1299 ± 8 for `alpha` = 111. It is 414 ± 6 for `alpha` = 347.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear | input | 1 | Synchronous zeroing of the filter state |
| period | input | 20 | Clocks between sample strikes |
| alpha | input | 16 | Unsigned coefficient, 16 fraction bits |
| shift_mode | input | 1 | 1 selects the power-of-two coefficient |
| shift_amt | input | 5 | Exponent m for shift mode |
| sample_in | input | 18 | Signed input sample, 17 fraction bits |
| sample_out | output | 18 | Signed rounded output, 17 fraction bits |
| out_valid | output | 1 | One-clock pulse after each strike |

## Verification
A strike is decided by the counter register in cycle t. The state register and the valid flag load at the edge that ends cycle t, and the rounded output is combinational from the state. Both results are therefore due one edge after the strike cycle. The same holds for the zeroing by `clear`. Reset release adds two edges of synchronizer delay before the counter starts. The bench drives and samples on the falling edge. It advances its own behavioural model by exactly one step per rising edge, with the same two-edge reset latency, so every clock is compared against the result due in that cycle.

// File: rtl/ema_pkg.sv
package ema_pkg;
  localparam int EMA_IN_W    = 18;
  localparam int EMA_IN_FRAC = 17;
  localparam int EMA_ST_W    = 40;
  localparam int EMA_ST_FRAC = 39;
  localparam int EMA_A_W     = 16;
  localparam int EMA_SH_W    = 5;
  localparam int EMA_CNT_W   = 20;
endpackage

// File: rtl/ema_rst_sync.sv
module ema_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_ns = sync_q;
endmodule

// File: rtl/ema_pacer.sv
module ema_pacer #(
  parameter int CNT_W = ema_pkg::EMA_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  output logic             strike
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last   = (period == '0) ? '0 : period - 1'b1;
    strike = (cnt_q >= last);
    cnt_d  = strike ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the counter restarts after a strike and steps by one otherwise
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    strike |=> (cnt_q == '0));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !strike |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ema_update.sv
module ema_update #(
  parameter int IN_W    = ema_pkg::EMA_IN_W,
  parameter int IN_FRAC = ema_pkg::EMA_IN_FRAC,
  parameter int ST_W    = ema_pkg::EMA_ST_W,
  parameter int ST_FRAC = ema_pkg::EMA_ST_FRAC,
  parameter int A_W     = ema_pkg::EMA_A_W,
  parameter int SH_W    = ema_pkg::EMA_SH_W
) (
  input  logic [ST_W-1:0] state_q,
  input  logic [IN_W-1:0] x_in,
  input  logic [A_W-1:0]  alpha,
  input  logic            shift_mode,
  input  logic [SH_W-1:0] shift_amt,
  output logic [ST_W-1:0] state_nx
);
  localparam int X_SH  = ST_FRAC - IN_FRAC;
  localparam int D_W   = ST_W + 1;
  localparam int P_W   = D_W + A_W + 1;

  logic signed [D_W-1:0] x_ext, y_ext, diff, inc_mul, inc_sh, inc, sum;
  logic signed [P_W-1:0] prod, prod_sh;

  always_comb begin
    x_ext   = $signed({{(D_W-IN_W){x_in[IN_W-1]}}, x_in}) <<< X_SH;
    y_ext   = $signed({state_q[ST_W-1], state_q});
    diff    = x_ext - y_ext;
    prod    = diff * $signed({1'b0, alpha});
    prod_sh = prod >>> A_W;
    inc_mul = prod_sh[D_W-1:0];
    inc_sh  = diff >>> shift_amt;
    inc     = shift_mode ? inc_sh : inc_mul;
    sum     = y_ext + inc;
    state_nx = sum[ST_W-1:0];
  end
endmodule

// File: rtl/ema_round.sv
module ema_round #(
  parameter int IN_W    = ema_pkg::EMA_IN_W,
  parameter int IN_FRAC = ema_pkg::EMA_IN_FRAC,
  parameter int ST_W    = ema_pkg::EMA_ST_W,
  parameter int ST_FRAC = ema_pkg::EMA_ST_FRAC
) (
  input  logic [ST_W-1:0] state_q,
  output logic [IN_W-1:0] y_out
);
  localparam int DROP = ST_FRAC - IN_FRAC;
  localparam int HI_W = ST_W + 1 - DROP;

  logic signed [ST_W:0]   biased;
  logic signed [HI_W-1:0] hi;

  always_comb begin
    biased = $signed({state_q[ST_W-1], state_q})
           + $signed({{(ST_W+1-DROP){1'b0}}, 1'b1, {(DROP-1){1'b0}}});
    hi = biased[ST_W:DROP];
    if (hi > $signed({{(HI_W-IN_W+1){1'b0}}, {(IN_W-1){1'b1}}}))
      y_out = {1'b0, {(IN_W-1){1'b1}}};
    else if (hi < $signed({{(HI_W-IN_W+1){1'b1}}, {(IN_W-1){1'b0}}}))
      y_out = {1'b1, {(IN_W-1){1'b0}}};
    else
      y_out = hi[IN_W-1:0];
  end
endmodule

// File: rtl/ema_smoother.sv
module ema_smoother #(
  parameter int IN_W    = ema_pkg::EMA_IN_W,
  parameter int IN_FRAC = ema_pkg::EMA_IN_FRAC,
  parameter int ST_W    = ema_pkg::EMA_ST_W,
  parameter int ST_FRAC = ema_pkg::EMA_ST_FRAC,
  parameter int A_W     = ema_pkg::EMA_A_W,
  parameter int SH_W    = ema_pkg::EMA_SH_W,
  parameter int CNT_W   = ema_pkg::EMA_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] period,
  input  logic [A_W-1:0]   alpha,
  input  logic             shift_mode,
  input  logic [SH_W-1:0]  shift_amt,
  input  logic [IN_W-1:0]  sample_in,
  output logic [IN_W-1:0]  sample_out,
  output logic             out_valid
);
  logic            rst_ns, strike;
  logic [ST_W-1:0] state_q, state_d, state_nx;
  logic            state_en, valid_q, valid_d;

  ema_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  ema_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk(clk), .rst_n(rst_ns), .period(period), .strike(strike));

  ema_update #(.IN_W(IN_W), .IN_FRAC(IN_FRAC), .ST_W(ST_W), .ST_FRAC(ST_FRAC),
               .A_W(A_W), .SH_W(SH_W)) u_upd (
    .state_q(state_q), .x_in(sample_in), .alpha(alpha),
    .shift_mode(shift_mode), .shift_amt(shift_amt), .state_nx(state_nx));

  ema_round #(.IN_W(IN_W), .IN_FRAC(IN_FRAC), .ST_W(ST_W), .ST_FRAC(ST_FRAC)) u_rnd (
    .state_q(state_q), .y_out(sample_out));

  always_comb begin
    state_en = clear | strike;
    state_d  = state_q;
    valid_d  = 1'b0;
    if (clear) begin
      state_d = '0;
    end else if (strike) begin
      state_d = state_nx;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (state_en) state_q <= state_d;
    end
  end

  assign out_valid = valid_q;

  // R2: an unblocked strike is followed by a valid pulse
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_ns)
    (strike && !clear) |=> out_valid);
  // R5: the output holds between strikes and clears
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (!strike && !clear) |=> $stable(sample_out));
  // R6: clear zeroes the output and blocks the valid pulse
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_ns)
    clear |=> (sample_out == '0 && !out_valid));
  // R4: a zero shift copies the sample straight through
  a_r4_copy: assert property (@(posedge clk) disable iff (!rst_ns)
    (strike && !clear && shift_mode && shift_amt == '0) |=> (sample_out == $past(sample_in)));
endmodule

// File: tb/test_ema_smoother.sv
module test_ema_smoother;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, clear, shift_mode;
  logic [19:0] period;
  logic [15:0] alpha;
  logic [4:0]  shift_amt;
  logic [17:0] sample_in;
  logic [17:0] sample_out;
  logic        out_valid;

  int     n_vec = 0, n_fail = 0, cyc_no = 0;
  longint m_state = 0;
  bit     m_valid = 0;
  int     m_cnt = 0, m_rel = 0;
  string  cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ema_smoother i_ema_smoother (
    .clk(clk), .rst_n(rst_n), .clear(clear), .period(period), .alpha(alpha),
    .shift_mode(shift_mode), .shift_amt(shift_amt), .sample_in(sample_in),
    .sample_out(sample_out), .out_valid(out_valid));

  function automatic longint ref_step(longint y);
    longint x, d, inc;
    x = longint'($signed(sample_in)) <<< 22;
    d = x - y;
    if (shift_mode) inc = d >>> shift_amt;
    else            inc = (d * longint'(alpha)) >>> 16;
    return y + inc;
  endfunction

  function automatic longint ref_round(longint y);
    longint r;
    r = (y + (64'sd1 <<< 21)) >>> 22;
    if (r > 131071)  r = 131071;
    if (r < -131072) r = -131072;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    longint ns;
    int nc, last;
    bit nv, st;
    ns = m_state; nv = 0; nc = m_cnt;
    if (!rst_n || m_rel < 2) begin
      ns = 0; nc = 0;
    end else begin
      last = (period == 0) ? 0 : int'(period) - 1;
      st = (m_cnt >= last);
      nc = st ? 0 : m_cnt + 1;
      if (clear) ns = 0;
      else if (st) begin ns = ref_step(m_state); nv = 1; end
    end
    @(posedge clk);
    m_rel = rst_n ? ((m_rel < 2) ? m_rel + 1 : 2) : 0;
    m_state = ns; m_cnt = nc; m_valid = nv;
    cyc_no++;
    @(negedge clk);
    check(longint'($signed(sample_out)) == ref_round(m_state), cur_req, "sample_out",
          longint'($signed(sample_out)), ref_round(m_state));
    check(out_valid == m_valid, cur_req, "out_valid", longint'(out_valid), longint'(m_valid));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic rise(logic [15:0] a, int expect_n, int tol, string req);
    int n, n10, n90;
    clear = 1'b1; cyc(); clear = 1'b0;
    period = 20'd1; shift_mode = 1'b0; alpha = a; sample_in = 18'h1FFFF;
    n = 0; n10 = -1; n90 = -1;
    for (int i = 0; i < 3000 && n90 < 0; i++) begin
      cyc();
      if (out_valid) begin
        n++;
        if (n10 < 0 && $signed(sample_out) >= 13107) n10 = n;
        if ($signed(sample_out) >= 117964) n90 = n;
      end
    end
    check((n10 >= 0) && (n90 >= 0) && ((n90 - n10) >= expect_n - tol) && ((n90 - n10) <= expect_n + tol),
          req, "rise strikes", n90 - n10, expect_n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    logic [17:0] held;
    rst_n = 1'b0; clear = 1'b0; period = 20'd5; alpha = 16'h8000;
    shift_mode = 1'b0; shift_amt = 5'd0; sample_in = 18'h10000;
    // R1: reset holds outputs at zero
    cur_req = "R1";
    run(4);
    check(sample_out == 18'd0 && !out_valid, "R1", "reset outputs", longint'(sample_out), 0);
    rst_n = 1'b1;
    run(12);
    // R3: multiply mode, positive and negative inputs
    cur_req = "R3";
    run(60);
    alpha = 16'h1234; sample_in = 18'h28000;
    run(80);
    alpha = 16'hFFFF; sample_in = 18'h00123;
    run(40);
    // R2: one valid pulse per five clocks
    cur_req = "R2";
    cnt = 0;
    for (int i = 0; i < 50; i++) begin cyc(); if (out_valid) cnt++; end
    check(cnt == 10, "R2", "valid count P=5", cnt, 10);
    // R4: shift mode
    cur_req = "R4";
    shift_mode = 1'b1; shift_amt = 5'd3; sample_in = 18'h0F000;
    run(60);
    shift_amt = 5'd0; sample_in = 18'h3FFFF;
    run(10);
    check(sample_out == 18'h3FFFF, "R4", "m=0 copies input", longint'(sample_out), longint'(18'h3FFFF));
    shift_amt = 5'd8; sample_in = 18'h1FFFF;
    run(60);
    // R5: rounding checked every clock
    cur_req = "R5";
    shift_mode = 1'b0; alpha = 16'h0003; sample_in = 18'h00001;
    run(60);
    // R6: clear
    cur_req = "R6";
    while (!out_valid) cyc();
    clear = 1'b1; cyc(); clear = 1'b0;
    check(sample_out == 18'd0, "R6", "clear zeroes", longint'(sample_out), 0);
    run(20);
    // R7: changes between strikes ignored
    cur_req = "R7";
    period = 20'd40; alpha = 16'h4000; sample_in = 18'h08000;
    while (!out_valid) cyc();
    held = sample_out;
    alpha = 16'hFFFF; shift_mode = 1'b1; shift_amt = 5'd0; sample_in = 18'h20000;
    run(20);
    check(sample_out == held, "R7", "output held", longint'(sample_out), longint'(held));
    alpha = 16'h4000; shift_mode = 1'b0; sample_in = 18'h08000;
    while (!out_valid) cyc();
    run(3);
    // R2: period 0 behaves as 1
    cur_req = "R2";
    period = 20'd0;
    cyc();
    cnt = 0;
    for (int i = 0; i < 10; i++) begin cyc(); if (out_valid) cnt++; end
    check(cnt == 10, "R2", "valid count P=0", cnt, 10);
    // R8: step response rise counts
    cur_req = "R8";
    rise(16'd111, 1299, 8, "R8");
    rise(16'd347, 414, 6, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule